// File: doc/BRIEF.md
# SPI Register Access Bridge

This block is an SPI target that gives an external host read and write access to a space of 32-bit registers inside the chip. Each transaction opens with 24 address bits sent most significant bit first. The top bit of those 24 marks a write. The remaining 23 bits are the word address, which is the byte address divided by four. A write carries one 32-bit payload and nothing more. On a read, the bridge first sends a host-chosen number of zero padding bytes and then returns the 32-bit word. The padding gives a slow internal access time to complete before the first data bit must leave.

Inside the chip, the bridge drives a request/acknowledge port with variable latency. It also keeps three local words of its own:
- an order-control word, which selects the byte order and bit order of payloads;
- a status word, which holds the padding count, a sticky flag for a read that came too late, and the identifier of the access path;
- a soft-reset trigger, which returns the other two words to their defaults.

Chip select is synchronised into the system clock and sampled there. The SPI clock and MOSI are handled the same way, and MISO is driven from that clock as well.

Top module: `spi_reg_bridge`

## Requirements
- R1: The 24 address bits arrive most significant bit first. Bit 23 set means a write and bit 23 clear means a read. Bits 22:0 appear unchanged on `reg_addr` for a non-local access.
- R2: A write frame produces exactly one internal request with `reg_we`=1, issued only after the 32nd payload bit. Raising chip select earlier drops the frame with no request and no local update.
- R3: A read frame issues one request with `reg_we`=0 once the address is complete. The acknowledged word is shifted out on MISO starting at bit position 24 + 8*pad of the frame.
- R4: MISO is low while chip select is inactive, during the address phase and during every padding bit.
- R5: The payload order follows order code m = ctrl[1:0]. m=00 is little-endian bytes with MSB first, m=01 is big-endian bytes with MSB first, m=10 is little-endian bytes with LSB first, and m=11 is big-endian bytes with LSB first. The same order applies to write data and to read data.
- R6: Writing a code repeated in every byte (0x81818181, 0xC3C3C3C3 or 0x42424242) to the order-control word (word address 0x400000) takes effect the same way under any current order, and the word reads back as written.
- R7: The status word (word address 0x400001) reads as {8'h02, 7'b0, late, 12'b0, pad[3:0]}. A write to it loads pad from data[3:0].
- R8: If the word for a read is not ready when its first data bit has to be driven, the late flag is set and the read returns all zeros. The flag stays set until the status word is written.
- R9: Writing data with bit 0 set to word address 0x400002 returns the order code, the padding count and the late flag to zero. That address always reads as zero.
- R10: An internal request stays high, with address, direction and data unchanged, until the cycle in which `reg_ack` is high.
- R11: After reset, `spi_miso` and `reg_req` are low, the order code is 00 and the padding count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI clock, mode 0 |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Data from host, sampled on rising SCLK |
| spi_miso | output | 1 | Data to host, changed on falling SCLK |
| reg_req | output | 1 | Internal access request, held until acknowledged |
| reg_we | output | 1 | 1 for a write request, 0 for a read |
| reg_addr | output | 23 | Word address of the request |
| reg_wdata | output | 32 | Write data |
| reg_rdata | input | 32 | Read data, valid with `reg_ack` |
| reg_ack | input | 1 | One-cycle acknowledge of the request |

## Verification
Two events can land in the same SCLK half period: the acknowledge of a read and the falling edge that must load that read's first data bit. The bench makes them collide on purpose. It sets the responder latency longer than half an SCLK period while the padding is zero, and then with padding large enough to absorb that latency. The first case must return zeros and raise the late flag, which a later status read brings out. The second case must return the stored word with the flag still clear.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;
  localparam int ADDR_BITS = 24;
  localparam int ADDR_W    = ADDR_BITS - 1;
  localparam int WORD_W    = 32;

  // Payload position (0 = first bit on the wire) to word bit index.
  // mode[0]: big-endian byte order, mode[1]: LSB first within a byte.
  function automatic logic [4:0] payload_bit_idx(input logic [1:0] mode, input logic [4:0] pos);
    logic [1:0] byte_n;
    logic [2:0] bit_n;
    byte_n = mode[0] ? (2'd3 - pos[4:3]) : pos[4:3];
    bit_n  = mode[1] ? pos[2:0] : (3'd7 - pos[2:0]);
    return {byte_n, bit_n};
  endfunction

  function automatic logic [WORD_W-1:0] status_word(input logic [3:0] pad, input logic late,
                                                    input logic [7:0] if_id);
    return {if_id, 7'b0, late, 12'b0, pad};
  endfunction
endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[s] <= RST_VAL;
        else if (s == 0) stage[s] <= d;
        else stage[s] <= stage[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/spi_rb_ifregs.sv
module spi_rb_ifregs import spi_rb_pkg::*; #(
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 23'h400000,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 23'h400001,
  parameter logic [ADDR_W-1:0] SRST_ADDR = 23'h400002,
  parameter logic [7:0]        IF_ID     = 8'd2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              wr_stb,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              late_evt,
  output logic              loc_hit,
  output logic [WORD_W-1:0] loc_rd,
  output logic [1:0]        mode,
  output logic [3:0]        pad,
  output logic              late_flag,
  output logic              srst_evt
);
  logic [WORD_W-1:0] ctrl_q;
  logic              hit_ctrl, hit_stat, hit_srst;

  assign hit_ctrl = (acc_addr == CTRL_ADDR);
  assign hit_stat = (acc_addr == STAT_ADDR);
  assign hit_srst = (acc_addr == SRST_ADDR);
  assign loc_hit  = hit_ctrl | hit_stat | hit_srst;
  assign srst_evt = wr_stb & hit_srst & wr_data[0];
  assign mode     = ctrl_q[1:0];

  always_comb begin
    loc_rd = '0;
    if (hit_ctrl)      loc_rd = ctrl_q;
    else if (hit_stat) loc_rd = status_word(pad, late_flag, IF_ID);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      pad       <= '0;
      late_flag <= 1'b0;
    end else if (srst_evt) begin
      ctrl_q    <= '0;
      pad       <= '0;
      late_flag <= 1'b0;
    end else begin
      if (wr_stb && hit_ctrl) ctrl_q <= wr_data;
      if (wr_stb && hit_stat) begin
        pad       <= wr_data[3:0];
        late_flag <= 1'b0;
      end
      if (late_evt) late_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/spi_reg_bridge.sv
module spi_reg_bridge import spi_rb_pkg::*; #(
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 23'h400000,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 23'h400001,
  parameter logic [ADDR_W-1:0] SRST_ADDR = 23'h400002,
  parameter logic [7:0]        IF_ID     = 8'd2,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              reg_req,
  output logic              reg_we,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [WORD_W-1:0] reg_wdata,
  input  logic [WORD_W-1:0] reg_rdata,
  input  logic              reg_ack
);
  localparam int FRAME_MAX = ADDR_BITS + 8 * 15 + WORD_W;
  localparam int CNT_W     = $clog2(FRAME_MAX + 1);
  localparam logic [CNT_W-1:0] LAST_ADDR = CNT_W'(ADDR_BITS - 1);
  localparam logic [CNT_W-1:0] DATA_LO   = CNT_W'(ADDR_BITS);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(ADDR_BITS + WORD_W - 1);

  logic sck_s, cs_n_s, mosi_s, sck_q;
  logic cs_act, sck_rise, sck_fall;

  spi_rb_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_sclk, spi_cs_n, spi_mosi}),
    .q({sck_s, cs_n_s, mosi_s})
  );

  assign cs_act   = !cs_n_s;
  assign sck_rise = sck_s & !sck_q;
  assign sck_fall = !sck_s & sck_q;

  logic [CNT_W-1:0]     bitcnt;
  logic [ADDR_W-1:0]    sh;
  logic [ADDR_W-1:0]    acc_addr;
  logic                 is_wr;
  logic [WORD_W-1:0]    wbuf, rd_buf;
  logic                 rd_ready, out_ok, pend_rd, miso_q;
  logic                 req_q, we_q;
  logic [ADDR_W-1:0]    raddr_q;
  logic [WORD_W-1:0]    wdata_q;

  // Named events for the checker.
  logic ev_rd_launch, ev_commit, ev_late, ev_srst;
  logic loc_hit, late_flag;
  logic [WORD_W-1:0] loc_rd;
  logic [1:0] cur_mode;
  logic [3:0] cur_pad;

  logic [CNT_W-1:0] first_bit, wpos_full, rpos_full;
  logic             rd_frame, in_data;

  assign first_bit = DATA_LO + CNT_W'({cur_pad, 3'b000});
  assign wpos_full = bitcnt - DATA_LO;
  assign rpos_full = bitcnt - first_bit;
  assign rd_frame  = !is_wr && (bitcnt >= DATA_LO);
  assign in_data   = rd_frame && (bitcnt >= first_bit) && (bitcnt < first_bit + CNT_W'(WORD_W));
  assign ev_late   = cs_act && sck_fall && rd_frame && (bitcnt == first_bit) && !rd_ready;

  spi_rb_ifregs #(.CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR), .SRST_ADDR(SRST_ADDR),
                  .IF_ID(IF_ID)) u_ifregs (
    .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr),
    .wr_stb(ev_commit && loc_hit), .wr_data(wbuf), .late_evt(ev_late),
    .loc_hit(loc_hit), .loc_rd(loc_rd), .mode(cur_mode), .pad(cur_pad),
    .late_flag(late_flag), .srst_evt(ev_srst)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0; bitcnt <= '0; sh <= '0; acc_addr <= '0; is_wr <= 1'b0;
      wbuf <= '0; rd_buf <= '0; rd_ready <= 1'b0; out_ok <= 1'b0; pend_rd <= 1'b0;
      miso_q <= 1'b0; req_q <= 1'b0; we_q <= 1'b0; raddr_q <= '0; wdata_q <= '0;
      ev_rd_launch <= 1'b0; ev_commit <= 1'b0;
    end else begin
      sck_q        <= sck_s;
      ev_rd_launch <= 1'b0;
      ev_commit    <= 1'b0;

      // Internal port completion.
      if (req_q && reg_ack) begin
        req_q   <= 1'b0;
        pend_rd <= 1'b0;
        if (!we_q && pend_rd) begin
          rd_buf   <= reg_rdata;
          rd_ready <= 1'b1;
        end
      end

      // Read launch one cycle after the address completes.
      if (ev_rd_launch) begin
        if (loc_hit) begin
          rd_buf   <= loc_rd;
          rd_ready <= 1'b1;
        end else if (!req_q) begin
          req_q <= 1'b1; we_q <= 1'b0; raddr_q <= acc_addr; pend_rd <= 1'b1;
        end
      end

      // Write commit one cycle after the last payload bit.
      if (ev_commit && !loc_hit && !req_q) begin
        req_q <= 1'b1; we_q <= 1'b1; raddr_q <= acc_addr; wdata_q <= wbuf;
      end

      if (!cs_act) begin
        bitcnt <= '0; is_wr <= 1'b0; rd_ready <= 1'b0; out_ok <= 1'b0;
        pend_rd <= 1'b0; miso_q <= 1'b0;
      end else begin
        if (sck_rise) begin
          sh <= {sh[ADDR_W-2:0], mosi_s};
          if (bitcnt != '1) bitcnt <= bitcnt + 1'b1;
          if (bitcnt == LAST_ADDR) begin
            is_wr        <= sh[ADDR_W-1];
            acc_addr     <= {sh[ADDR_W-2:0], mosi_s};
            ev_rd_launch <= !sh[ADDR_W-1];
          end
          if (is_wr && bitcnt >= DATA_LO && bitcnt <= LAST_DATA)
            wbuf[payload_bit_idx(cur_mode, wpos_full[4:0])] <= mosi_s;
          if (is_wr && bitcnt == LAST_DATA) ev_commit <= 1'b1;
        end
        if (sck_fall) begin
          if (in_data) begin
            if (bitcnt == first_bit) begin
              out_ok <= rd_ready;
              miso_q <= rd_ready & rd_buf[payload_bit_idx(cur_mode, 5'd0)];
            end else begin
              miso_q <= out_ok & rd_buf[payload_bit_idx(cur_mode, rpos_full[4:0])];
            end
          end else begin
            miso_q <= 1'b0;
          end
        end
      end
    end
  end

  assign spi_miso  = miso_q;
  assign reg_req   = req_q;
  assign reg_we    = we_q;
  assign reg_addr  = raddr_q;
  assign reg_wdata = wdata_q;
endmodule

// File: rtl/spi_rb_checker.sv
module spi_rb_checker import spi_rb_pkg::*; (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_act,
  input logic              spi_miso,
  input logic              reg_req,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [WORD_W-1:0] reg_wdata,
  input logic              reg_ack,
  input logic              ev_rd_launch,
  input logic              ev_commit,
  input logic              ev_late,
  input logic              ev_srst,
  input logic              late_flag,
  input logic [1:0]        cur_mode,
  input logic [3:0]        cur_pad
);
  assert_miso_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !spi_miso);

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && !reg_ack |=> reg_req && $stable(reg_addr) && $stable(reg_we) && $stable(reg_wdata));

  assert_late_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_late |=> late_flag);

  assert_write_after_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_req) && reg_we |-> $past(ev_commit));

  assert_read_after_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_req) && !reg_we |-> $past(ev_rd_launch));

  assert_one_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_commit, ev_rd_launch}));

  assert_srst_defaults_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_srst |=> cur_mode == 2'b00 && cur_pad == 4'd0 && !late_flag);
endmodule

bind spi_reg_bridge spi_rb_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .spi_miso(spi_miso),
  .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_ack(reg_ack), .ev_rd_launch(ev_rd_launch), .ev_commit(ev_commit),
  .ev_late(ev_late), .ev_srst(ev_srst), .late_flag(late_flag),
  .cur_mode(cur_mode), .cur_pad(cur_pad)
);

// File: tb/tb_spi_reg_bridge.sv
module tb_spi_reg_bridge;
  localparam int HALF = 8;
  localparam logic [22:0] A_CTRL = 23'h400000;
  localparam logic [22:0] A_STAT = 23'h400001;
  localparam logic [22:0] A_SRST = 23'h400002;

  logic clk = 1'b0, rst_n = 1'b0;
  logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic spi_miso, reg_req, reg_we, reg_ack = 1'b0;
  logic [22:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata = '0;

  always #2.5 clk = ~clk;

  spi_reg_bridge dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .reg_req(reg_req), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_ack(reg_ack)
  );

  int n_tests = 0, n_fail = 0;
  int lat = 2;
  int tb_pad = 0;
  logic [1:0] tb_mode = 2'b00;
  logic [31:0] mem [logic [22:0]];
  logic [54:0] exp_wq [$];
  bit finished = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int wire_to_bit(input logic [1:0] m, input int p);
    case (m)
      2'b01:   return 31 - p;
      2'b00:   return (p / 8) * 8 + 7 - (p % 8);
      2'b10:   return p;
      default: return (3 - p / 8) * 8 + (p % 8);
    endcase
  endfunction

  // Behavioural responder and per-clock write checker (R1, R2, R10).
  int wait_cnt = 0;
  logic [22:0] held_addr;
  always @(negedge clk) begin
    if (!rst_n) begin
      reg_ack = 1'b0; wait_cnt = 0;
    end else if (reg_ack) begin
      reg_ack = 1'b0;
    end else if (reg_req) begin
      if (wait_cnt == 0) held_addr = reg_addr;
      else if (reg_addr !== held_addr) check("R10 addr held", {9'b0, reg_addr}, {9'b0, held_addr});
      wait_cnt++;
      if (wait_cnt >= lat) begin
        if (reg_we) begin
          if (exp_wq.size() == 0) begin
            check("R2 unexpected write", {9'b0, reg_addr}, 32'hFFFF_FFFF);
          end else begin
            logic [54:0] e;
            e = exp_wq.pop_front();
            check("R1 write address", {9'b0, reg_addr}, {9'b0, e[54:32]});
            check("R2 write data", reg_wdata, e[31:0]);
          end
          mem[reg_addr] = reg_wdata;
        end else begin
          reg_rdata = mem.exists(reg_addr) ? mem[reg_addr] : 32'h0;
        end
        reg_ack = 1'b1;
        wait_cnt = 0;
      end
    end
  end

  task automatic spi_frame(input bit wr, input logic [22:0] a, input logic [31:0] wd,
                           input int abort_at, output logic [31:0] rd, output bit pad_clean);
    logic [23:0] hdr;
    int nbits, first;
    hdr = {wr, a};
    first = 24 + 8 * tb_pad;
    nbits = wr ? 56 : first + 32;
    rd = '0;
    pad_clean = 1;
    @(negedge clk); spi_cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      if (abort_at >= 0 && i == abort_at) break;
      if (i < 24)  spi_mosi = hdr[23 - i];
      else if (wr) spi_mosi = wd[wire_to_bit(tb_mode, i - 24)];
      else         spi_mosi = 1'b0;
      repeat (HALF) @(negedge clk);
      if (!wr && i >= first) rd[wire_to_bit(tb_mode, i - first)] = spi_miso;
      else if (spi_miso !== 1'b0) pad_clean = 0;
      spi_sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (8 * HALF) @(negedge clk);
  endtask

  task automatic do_write(input logic [22:0] a, input logic [31:0] d);
    logic [31:0] dummy; bit pc;
    if (a != A_CTRL && a != A_STAT && a != A_SRST) exp_wq.push_back({a, d});
    spi_frame(1'b1, a, d, -1, dummy, pc);
  endtask

  task automatic do_read(input logic [22:0] a, output logic [31:0] rd, output bit pc);
    spi_frame(1'b0, a, 32'h0, -1, rd, pc);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] rd;
    bit pc;
    repeat (4) @(negedge clk);
    check("R11 miso after reset", {31'b0, spi_miso}, 32'h0);
    check("R11 req after reset", {31'b0, reg_req}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Order 00, external write and read back.
    do_write(23'h000123, 32'hDEADBEEF);
    check("R2 write queue drained", exp_wq.size(), 0);
    do_read(23'h000123, rd, pc);
    check("R3 read data mode00", rd, 32'hDEADBEEF);
    check("R4 address phase miso low", {31'b0, pc}, 32'h1);
    do_read(A_STAT, rd, pc);
    check("R11 status default", rd, 32'h0200_0000);

    // Switch to big-endian MSB first with replicated code.
    do_write(A_CTRL, 32'h81818181); tb_mode = 2'b01;
    do_read(A_CTRL, rd, pc);
    check("R6 ctrl readback 81", rd, 32'h81818181);
    do_write(23'h000200, 32'h12345678);
    do_read(23'h000200, rd, pc);
    check("R5 mode01 roundtrip", rd, 32'h12345678);
    do_read(23'h000123, rd, pc);
    check("R5 mode01 reads old word", rd, 32'hDEADBEEF);

    // Big-endian LSB first.
    do_write(A_CTRL, 32'hC3C3C3C3); tb_mode = 2'b11;
    do_read(A_CTRL, rd, pc);
    check("R6 ctrl readback C3", rd, 32'hC3C3C3C3);
    do_write(23'h000300, 32'hA5F00F5A);
    do_read(23'h000300, rd, pc);
    check("R5 mode11 roundtrip", rd, 32'hA5F00F5A);

    // Little-endian LSB first.
    do_write(A_CTRL, 32'h42424242); tb_mode = 2'b10;
    do_read(23'h000200, rd, pc);
    check("R5 mode10 reads word", rd, 32'h12345678);

    // Padding of two bytes with slow responder.
    do_write(A_STAT, 32'h0000_0002); tb_pad = 2;
    do_read(A_STAT, rd, pc);
    check("R7 status with pad", rd, 32'h0200_0002);
    check("R4 padding bits low", {31'b0, pc}, 32'h1);
    lat = 40;
    do_read(23'h000123, rd, pc);
    check("R3 padded slow read", rd, 32'hDEADBEEF);
    lat = 2;
    do_read(A_STAT, rd, pc);
    check("R8 no late flag when padded", rd, 32'h0200_0002);

    // No padding with slow responder: late.
    do_write(A_STAT, 32'h0000_0000); tb_pad = 0;
    lat = 40;
    do_read(23'h000123, rd, pc);
    check("R8 late read returns zero", rd, 32'h0);
    lat = 2;
    do_read(A_STAT, rd, pc);
    check("R8 late flag set", rd, 32'h0201_0000);
    do_read(A_STAT, rd, pc);
    check("R8 late flag sticky", rd, 32'h0201_0000);
    do_write(A_STAT, 32'h0000_0000);
    do_read(A_STAT, rd, pc);
    check("R8 late flag cleared by write", rd, 32'h0200_0000);

    // Aborted write.
    begin
      logic [31:0] dmy; bit p2;
      spi_frame(1'b1, 23'h000200, 32'hFFFF0000, 40, dmy, p2);
    end
    check("R2 abort leaves no request", exp_wq.size(), 0);
    do_read(23'h000200, rd, pc);
    check("R2 aborted write not applied", rd, 32'h12345678);

    // Soft reset.
    do_write(A_STAT, 32'h0000_0003); tb_pad = 3;
    do_write(A_SRST, 32'h0000_0001); tb_mode = 2'b00; tb_pad = 0;
    do_read(A_STAT, rd, pc);
    check("R9 status after soft reset", rd, 32'h0200_0000);
    do_read(A_CTRL, rd, pc);
    check("R9 ctrl after soft reset", rd, 32'h0);
    do_read(A_SRST, rd, pc);
    check("R9 soft reset reads zero", rd, 32'h0);
    do_read(23'h000300, rd, pc);
    check("R5 mode00 after soft reset", rd, 32'hA5F00F5A);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule